// File: doc/BRIEF.md
# Adaptive DC Tracking Bit Slicer

The slicer turns unsigned ADC codes from a zero-IF receiver into a raw binary level even though the baseline wanders. A first-order recursive lowpass follows the DC level: y[n] = a·x[n] + (1−a)·y[n−1], with a = 2^−k. The rounded estimate serves as a moving decision threshold. Each sample is compared against it, which gives a zero-crossing decision on the offset-removed signal. The resulting level goes to a later Manchester decoder. The block also outputs the signed offset-removed sample and the estimate itself.

The tracker is normally slow, so its corner sits far below the data band. When a jump in the baseline is known to be coming, the block can change gear in two ways. A fast request switches to a larger coefficient for a programmed number of samples. A snap loads the estimate straight from the present input sample, which is the a = 1 case.

Top module: `dc_track_slicer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after release, `out_valid` = 0, `out_bit` = 0, `out_ac` = 0 and `out_dc` = 2^(W−1) (mid-scale, 512 for W = 10). The estimate starts at exactly that value, with a zero fraction.
- R2: For each accepted sample x, `out_dc` gives the estimate held before that sample, rounded half-up to an integer. `out_ac` = x − `out_dc` as a signed two's-complement value. `out_bit` = 1 exactly when x > `out_dc`.
- R3: In slow gear, a sample updates the fixed-point estimate Y (an integer carrying K_SLOW fraction bits) as Y += ((x·2^K_SLOW) − Y) >>> K_SLOW, with an arithmetic shift that floors. With K_SLOW = 8 this gives a = 1/256.
- R4: A `fast_req` pulse without `snap` loads a window counter with `fast_len`. The counter is loaded on the edge that ends the pulse's cycle, so a sample accepted in that same cycle still uses the old gear. Each later accepted sample that finds the counter nonzero uses >>> K_FAST (3) in place of >>> K_SLOW and decrements the counter.
- R5: A sample accepted with `snap` high sets Y = x·2^K_SLOW and ignores the gear. The next sample's `out_dc` is then x.
- R6: While `snap` is high, `fast_req` is ignored. A snap together with a fast request leaves the window counter doing only its normal per-sample decrement.
- R7: Outputs are registered. `out_valid` is `in_valid` delayed by one cycle. On cycles without a sample, `out_dc`, `out_bit` and `out_ac` hold their values and the estimate does not move.
- R8: A `fast_req` with `fast_len` = 0 opens no fast window, so the samples that follow use slow gear. `snap` without `in_valid` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks a new ADC sample |
| in_sample | input | W | Unsigned ADC code |
| fast_req | input | 1 | Strobe that opens a fast-tracking window |
| snap | input | 1 | With in_valid, loads the estimate from the sample |
| fast_len | input | CNT_W | Length of the fast window in samples |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_bit | output | 1 | Sliced level: sample above the threshold |
| out_dc | output | W | Rounded DC estimate used for the decision |
| out_ac | output | W+1 | Signed offset-removed sample |

## Verification
The assertions assume that the strobes are clean single-cycle levels and that they are held low during reset, because several properties look one cycle back across the reset release. They also assume K_FAST is between 1 and K_SLOW, so that a step never overshoots the input and the accumulator cannot wrap. The stimulus drives every input at the falling edge, keeps all strobes low while reset is active, and uses the default coefficients. The sample values range from a mid-scale cluster to both far ends of the code range, and idle cycles sit between bursts.

// File: rtl/dcs_pkg.sv
// Shared types for the DC tracking slicer.
// Assumes nothing beyond what the modules that import it declare.
package dcs_pkg;
    // Tracking gear chosen for one sample
    typedef enum logic {
        GEAR_SLOW = 1'b0,
        GEAR_FAST = 1'b1
    } gear_e;
endpackage

// File: rtl/dcs_gear.sv
// Gear control: holds the fast-window counter and reports the gear for
// the current sample. Assumes the strobes are single-cycle levels that
// are low during reset.
module dcs_gear
    import dcs_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             fast_req,
    input  logic             snap,
    input  logic [CNT_W-1:0] fast_len,
    output gear_e            gear
);
    logic [CNT_W-1:0] win_cnt;
    logic             load_win;

    // Snap masks a fast request
    always_comb load_win = fast_req && !snap;

    // Window counter: load on a request, count down on each sample
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_cnt <= '0;
        else if (load_win)
            win_cnt <= fast_len;
        else if (in_valid && (win_cnt != '0))
            win_cnt <= win_cnt - 1'b1;
    end

    // Gear follows the window state
    always_comb gear = (win_cnt != '0) ? GEAR_FAST : GEAR_SLOW;

    // R4: a request without snap loads the programmed length
    assert_window_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fast_req && !snap) |-> win_cnt == $past(fast_len));

    // R6: with snap high the counter only takes its normal step
    assert_snap_masks_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(snap && in_valid && win_cnt != '0) |-> win_cnt == $past(win_cnt) - 1'b1);
endmodule

// File: rtl/dcs_tracker.sv
// Recursive DC tracker: fixed-point accumulator with FRAC fraction bits,
// updated by a shift of K_SLOW or K_FAST, or loaded by a snap. Gives the
// estimate before this sample's update, rounded half-up. Assumes
// 1 <= K_FAST <= K_SLOW = FRAC, so a step never overshoots the input.
module dcs_tracker
    import dcs_pkg::*;
#(
    parameter int W      = 10,
    parameter int K_SLOW = 8,
    parameter int K_FAST = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         snap,
    input  logic [W-1:0] in_sample,
    input  gear_e        gear,
    output logic [W-1:0] dc_round
);
    localparam int FRAC = K_SLOW;
    localparam int AW   = W + FRAC;
    localparam logic [AW-1:0] ACC_RESET = AW'(1) << (AW - 1);
    localparam logic [AW-1:0] ACC_MAX   = {{W{1'b1}}, {FRAC{1'b0}}};

    logic [AW-1:0]        acc;
    logic signed [AW:0]   diff;
    logic signed [AW:0]   step;
    logic signed [AW:0]   sum;
    logic [AW-1:0]        x_aligned;

    // Sample aligned to the fraction bits
    always_comb x_aligned = {in_sample, {FRAC{1'b0}}};

    // Error, shifted step and updated value
    always_comb begin
        diff = $signed({1'b0, x_aligned}) - $signed({1'b0, acc});
        step = (gear == GEAR_FAST) ? (diff >>> K_FAST) : (diff >>> K_SLOW);
        sum  = $signed({1'b0, acc}) + step;
    end

    // Accumulator: snap load, recursive update, or hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= ACC_RESET;
        else if (in_valid && snap)
            acc <= x_aligned;
        else if (in_valid)
            acc <= sum[AW-1:0];
    end

    // Half-up rounding: integer part plus the top fraction bit
    always_comb dc_round = acc[AW-1:FRAC] + W'(acc[FRAC-1]);

    // R3: the update never leaves the range of unsigned codes
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !snap |-> !sum[AW]);

    // R3: the estimate stays within the code range
    assert_acc_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc <= ACC_MAX);

    // R5: a snap puts the sample into the estimate exactly
    assert_snap_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && snap) |-> dc_round == $past(in_sample));

    // R7: no sample, no movement
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!in_valid) |-> $stable(acc));
endmodule

// File: rtl/dcs_decide.sv
// Decision stage: compares the sample with the rounded estimate and
// registers the level, estimate and offset-removed sample. Assumes
// dc_round is the estimate from before this sample's update.
module dcs_decide #(
    parameter int W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W-1:0]      in_sample,
    input  logic [W-1:0]      dc_round,
    output logic              out_valid,
    output logic              out_bit,
    output logic [W-1:0]      out_dc,
    output logic signed [W:0] out_ac
);
    localparam logic [W-1:0] MID = W'(1) << (W - 1);

    // Output registers: update on a sample, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            out_dc    <= MID;
            out_ac    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_bit <= (in_sample > dc_round);
                out_dc  <= dc_round;
                out_ac  <= $signed({1'b0, in_sample}) - $signed({1'b0, dc_round});
            end
        end
    end

    // R2: the level agrees with the sign of the offset-removed sample
    assert_bit_matches_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bit == (out_ac > 0)));

    // R7: one cycle of latency
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));
endmodule

// File: rtl/dc_track_slicer.sv
// Top of the DC tracking slicer: gear control, recursive tracker and
// decision stage. Assumes 1 <= K_FAST <= K_SLOW and strobes held low in
// reset.
module dc_track_slicer
    import dcs_pkg::*;
#(
    parameter int W      = 10,
    parameter int K_SLOW = 8,
    parameter int K_FAST = 3,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W-1:0]      in_sample,
    input  logic              fast_req,
    input  logic              snap,
    input  logic [CNT_W-1:0]  fast_len,
    output logic              out_valid,
    output logic              out_bit,
    output logic [W-1:0]      out_dc,
    output logic signed [W:0] out_ac
);
    gear_e        gear;
    logic [W-1:0] dc_round;

    dcs_gear #(.CNT_W(CNT_W)) u_gear (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .fast_req (fast_req),
        .snap     (snap),
        .fast_len (fast_len),
        .gear     (gear)
    );

    dcs_tracker #(.W(W), .K_SLOW(K_SLOW), .K_FAST(K_FAST)) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .snap      (snap),
        .in_sample (in_sample),
        .gear      (gear),
        .dc_round  (dc_round)
    );

    dcs_decide #(.W(W)) u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .dc_round  (dc_round),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_dc    (out_dc),
        .out_ac    (out_ac)
    );

    // R1: the first cycle after reset shows the reset state
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!out_valid && out_dc == (W'(1) << (W - 1))));
endmodule

// File: tb/dc_track_slicer_bench.sv
// Scoreboard bench: the driver pushes model results and the monitor pops
// and compares them when out_valid is seen.
module dc_track_slicer_bench;
    localparam int W = 10;
    localparam int KS = 8;
    localparam int KF = 3;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [W-1:0] in_sample = '0;
    logic fast_req = 1'b0;
    logic snap = 1'b0;
    logic [CW-1:0] fast_len = '0;
    logic out_valid, out_bit;
    logic [W-1:0] out_dc;
    logic signed [W:0] out_ac;

    always #2 clk = ~clk;

    dc_track_slicer #(.W(W), .K_SLOW(KS), .K_FAST(KF), .CNT_W(CW)) u_dc_track_slicer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .fast_req(fast_req), .snap(snap), .fast_len(fast_len),
        .out_valid(out_valid), .out_bit(out_bit), .out_dc(out_dc), .out_ac(out_ac)
    );

    typedef struct {
        int    bitv;
        int    dc;
        int    ac;
        string tag;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    int m_acc = 512 << KS;
    int m_cnt = 0;
    int last_dc = 512;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // Driver: one cycle of stimulus plus the model step
    task automatic drive(input bit v, input int x, input bit fr, input bit sn,
                         input int len, input string tag);
        exp_t e;
        int d;
        @(negedge clk);
        in_valid = v; in_sample = W'(x); fast_req = fr; snap = sn; fast_len = CW'(len);
        if (v) begin
            e.dc = (m_acc + (1 << (KS - 1))) >>> KS;
            e.ac = x - e.dc;
            e.bitv = (x > e.dc) ? 1 : 0;
            e.tag = tag;
            q.push_back(e);
            last_dc = e.dc;
            if (sn) m_acc = x << KS;
            else begin
                d = (x << KS) - m_acc;
                m_acc = m_acc + ((m_cnt != 0) ? (d >>> KF) : (d >>> KS));
            end
        end
        if (fr && !sn) m_cnt = len;
        else if (v && m_cnt != 0) m_cnt--;
    endtask

    // Monitor: compare each result with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) check(1'b0, "R7 unexpected out_valid", 1, 0);
            else begin
                exp_t e;
                e = q.pop_front();
                check(out_dc == W'(e.dc), {e.tag, " R2 out_dc"}, int'(out_dc), e.dc);
                check(int'(out_ac) == e.ac, {e.tag, " R2 out_ac"}, int'(out_ac), e.ac);
                check(int'(out_bit) == e.bitv, {e.tag, " R2 out_bit"}, int'(out_bit), e.bitv);
            end
        end
    end

    task automatic idle_check(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 0, 1'b0, 1'b0, 0, "R7");
        @(negedge clk);
        check(!out_valid, "R7 idle out_valid", int'(out_valid), 0);
        check(int'(out_dc) == last_dc, "R7 idle out_dc hold", int'(out_dc), last_dc);
    endtask

    initial begin
        int pat[5];
        pat = '{437, 480, 502, 476, 431};
        repeat (3) @(negedge clk);
        check(!out_valid, "R1 out_valid", int'(out_valid), 0);
        check(out_dc == 10'd512, "R1 out_dc", int'(out_dc), 512);
        check(out_ac == 0, "R1 out_ac", int'(out_ac), 0);
        check(!out_bit, "R1 out_bit", int'(out_bit), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_dc == 10'd512 && !out_valid, "R1 after release", int'(out_dc), 512);

        // R3 slow tracking of a mid-scale cluster
        for (int i = 0; i < 60; i++) drive(1'b1, pat[i % 5], 1'b0, 1'b0, 0, "R3 slow");
        idle_check(3);
        // R8 snap without a sample is ignored
        drive(1'b0, 900, 1'b0, 1'b1, 0, "R8");
        drive(1'b1, 470, 1'b0, 1'b0, 0, "R8 snap no valid");
        // R4 fast window around a baseline step, including same-cycle sample
        drive(1'b1, 300, 1'b1, 1'b0, 20, "R4 req cycle");
        for (int i = 0; i < 30; i++) drive(1'b1, (i % 2) ? 330 : 270, 1'b0, 1'b0, 0, "R4 fast");
        // R5 snap to a high level, then track
        drive(1'b1, 1000, 1'b0, 1'b1, 0, "R5 snap");
        for (int i = 0; i < 8; i++) drive(1'b1, (i % 2) ? 1023 : 980, 1'b0, 1'b0, 0, "R5 after");
        drive(1'b1, 0, 1'b0, 1'b1, 0, "R5 snap low");
        for (int i = 0; i < 6; i++) drive(1'b1, i * 3, 1'b0, 1'b0, 0, "R5 low");
        // R6 snap with fast request: request ignored
        drive(1'b1, 500, 1'b1, 1'b1, 40, "R6 snap+req");
        for (int i = 0; i < 10; i++) drive(1'b1, 600, 1'b0, 1'b0, 0, "R6 slow after");
        // R6 snap inside an open window only takes its normal step
        drive(1'b1, 600, 1'b1, 1'b0, 4, "R6 open");
        drive(1'b1, 400, 1'b1, 1'b1, 50, "R6 snap in window");
        for (int i = 0; i < 8; i++) drive(1'b1, 200, 1'b0, 1'b0, 0, "R6 window end");
        // R8 zero-length window
        drive(1'b0, 0, 1'b1, 1'b0, 0, "R8");
        for (int i = 0; i < 6; i++) drive(1'b1, 800, 1'b0, 1'b0, 0, "R8 len0 slow");
        idle_check(4);
        @(negedge clk);
        check(q.size() == 0, "R7 queue drained", q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule